// File: doc/BRIEF.md
# FIFO-Level Interrupt Unit

This block raises interrupts for a memory controller that stages write data in a program FIFO and returns fetched data through a read FIFO. Each FIFO is `DEPTH` words deep (16 by default). The FIFOs live elsewhere and report only their current occupancy to this unit. The unit also takes a one-cycle pulse when an operation finishes and a one-cycle pulse when a correctable error is seen.

There are six interrupt sources. Four are live status sources that follow FIFO conditions:
- program FIFO empty;
- program FIFO drained to its watermark;
- read FIFO full;
- read FIFO filled to its watermark.

Two are sticky event sources, for operation done and correctable error. A small word-wide register port, with a 3-bit word address and combinational read data, gives software access to:
- the interrupt state;
- a per-source enable mask;
- a write-only force register;
- the two watermark levels;
- a FIFO reset control;
- a read-only view of both depths.

Each interrupt line is its state bit gated by its enable bit. The state register updates on the clock edge after its inputs change.

Top module: `fifo_irq_unit`

Register map (word address: contents):
- 0 STATE: the six source bits.
- 1 ENABLE: the enable mask, bits 5:0.
- 2 FORCE: write-only, bits 5:0.
- 3 WMARK: program level in bits 4:0, read level in bits 12:8.
- 4 FCLR: bit 0.
- 5 DEPTH: program depth in bits 4:0, read depth in bits 12:8.

State bit order, from bit 0 up:
- bit 0: program empty;
- bit 1: program at level;
- bit 2: read full;
- bit 3: read at level;
- bit 4: operation done;
- bit 5: correctable error.

## Requirements
- R1: After reset, STATE reads 0x3, ENABLE reads 0, WMARK reads 0x0F0F, FCLR reads 0, `irq_o` is 0 and `fifo_clr_o` is 0.
- R2: STATE bit 0 is 1 exactly when the program depth sampled at the previous clock edge was 0.
- R3: STATE bit 1 is 1 exactly when the previous-edge program depth was less than or equal to the program level (WMARK bits 4:0).
- R4: STATE bit 2 is 1 exactly when the previous-edge read depth equalled `DEPTH`.
- R5: STATE bit 3 is 1 exactly when the previous-edge read depth was greater than or equal to the read level (WMARK bits 12:8).
- R6: Writing 1s to STATE bits 0 to 3 has no effect; those bits keep following their conditions.
- R7: STATE bit 4 (operation done) and bit 5 (correctable error) are set by their input pulse and stay set until software writes 1 to that bit of STATE. A set pulse in the same cycle as the clearing write leaves the bit set.
- R8: Writing 1 to a bit of FORCE sets the matching STATE bit. A status bit (0 to 3) then holds 1 for one cycle only, unless its condition is true. An event bit (4 or 5) stays latched until cleared. FORCE reads as 0.
- R9: `irq_o[i]` equals STATE bit i ANDed with ENABLE bit i.
- R10: FCLR bit 0 is read/write, and `fifo_clr_o` equals it.
- R11: DEPTH reads the live program depth in bits 4:0 and the live read depth in bits 12:8.
- R12: Addresses 6 and 7 read 0. ENABLE and STATE read 0 above bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| prog_depth_i | input | CW (5) | Current program FIFO occupancy |
| rd_depth_i | input | CW (5) | Current read FIFO occupancy |
| op_done_i | input | 1 | One-cycle operation-complete pulse |
| corr_err_i | input | 1 | One-cycle correctable-error pulse |
| irq_o | output | 6 | Per-source interrupt lines |
| fifo_clr_o | output | 1 | Holds both FIFOs in reset while 1 |

## Verification
The hardest case to reach is a hardware set pulse that lands in the same cycle as a software clear of that same event bit. From the ports this needs an event pulse and a register write driven on one exact edge. The bench drives `op_done_i` and a STATE write with bit 4 set together on one falling edge, then reads the bit back after the next rising edge. A second hard case is the one-cycle life of a forced status bit. The bench first moves both FIFO depths so that every status condition is false, writes FORCE, and then reads STATE on the two following cycles.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int unsigned NUM_SRC    = 6;
  localparam int unsigned NUM_STATUS = 4;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned RD_LSB     = 8;

  localparam logic [ADDR_W-1:0] ADR_STATE = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_EN    = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_FORCE = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_WMARK = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_FCLR  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_DEPTH = 3'd5;

  localparam int unsigned SRC_PROG_EMPTY = 0;
  localparam int unsigned SRC_PROG_LVL   = 1;
  localparam int unsigned SRC_RD_FULL    = 2;
  localparam int unsigned SRC_RD_LVL     = 3;
  localparam int unsigned SRC_OP_DONE    = 4;
  localparam int unsigned SRC_CORR_ERR   = 5;

  localparam logic [NUM_SRC-1:0] STATE_RST = 6'h03;
endpackage

// File: rtl/fifo_irq_cfg.sv
module fifo_irq_cfg
  import fifo_irq_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [CW-1:0]     prog_lvl_o,
  output logic [CW-1:0]     rd_lvl_o,
  output logic              fclr_o
);
  localparam logic [CW-1:0] LVL_RST = CW'(15);

  logic              en_we, wm_we, fc_we;
  logic [NUM_SRC-1:0] en_d, en_q;
  logic [CW-1:0]     pl_d, pl_q, rl_d, rl_q;
  logic              fc_d, fc_q;

  assign en_we = wr_i && (addr_i == ADR_EN);
  assign wm_we = wr_i && (addr_i == ADR_WMARK);
  assign fc_we = wr_i && (addr_i == ADR_FCLR);

  always_comb begin
    en_d = en_q;
    pl_d = pl_q;
    rl_d = rl_q;
    fc_d = fc_q;
    if (en_we) en_d = wdata_i[NUM_SRC-1:0];
    if (wm_we) begin
      pl_d = wdata_i[CW-1:0];
      rl_d = wdata_i[RD_LSB +: CW];
    end
    if (fc_we) fc_d = wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      pl_q <= LVL_RST;
      rl_q <= LVL_RST;
      fc_q <= 1'b0;
    end else begin
      en_q <= en_d;
      pl_q <= pl_d;
      rl_q <= rl_d;
      fc_q <= fc_d;
    end
  end

  assign en_o       = en_q;
  assign prog_lvl_o = pl_q;
  assign rd_lvl_o   = rl_q;
  assign fclr_o     = fc_q;

  AST_FCLR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fc_we |=> (fclr_o == $past(fclr_o))); // R10
endmodule

// File: rtl/fifo_irq_cond.sv
module fifo_irq_cond
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input  logic [CW-1:0]         prog_depth_i,
  input  logic [CW-1:0]         rd_depth_i,
  input  logic [CW-1:0]         prog_lvl_i,
  input  logic [CW-1:0]         rd_lvl_i,
  output logic [NUM_STATUS-1:0] cond_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  always_comb begin
    cond_o                 = '0;
    cond_o[SRC_PROG_EMPTY] = (prog_depth_i == '0);
    cond_o[SRC_PROG_LVL]   = (prog_depth_i <= prog_lvl_i);
    cond_o[SRC_RD_FULL]    = (rd_depth_i == FULL_CNT);
    cond_o[SRC_RD_LVL]     = (rd_depth_i >= rd_lvl_i);
  end
endmodule

// File: rtl/fifo_irq_state.sv
module fifo_irq_state
  import fifo_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] hw_set_i,
  input  logic [NUM_SRC-1:0] force_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] state_o
);
  logic [NUM_SRC-1:0] st_d, st_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i < NUM_STATUS) begin : g_status
      assign st_d[i] = hw_set_i[i] | force_i[i];

      AST_STATUS_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hw_set_i[i] && !force_i[i]) |=> !state_o[i]); // R6
    end else begin : g_event
      assign st_d[i] = hw_set_i[i] | force_i[i] | (st_q[i] & ~clr_i[i]);

      AST_EVENT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o[i] && !clr_i[i]) |=> state_o[i]); // R7
      AST_EVENT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[i] && !hw_set_i[i] && !force_i[i]) |=> !state_o[i]); // R7
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= STATE_RST;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [CW-1:0]     prog_depth_i,
  input  logic [CW-1:0]     rd_depth_i,
  input  logic              op_done_i,
  input  logic              corr_err_i,
  output logic [NUM_SRC-1:0] irq_o,
  output logic              fifo_clr_o
);
  logic [1:0]            rst_sync_q;
  logic                  rst_n;
  logic [NUM_SRC-1:0]    en;
  logic [CW-1:0]         prog_lvl, rd_lvl;
  logic [NUM_STATUS-1:0] cond;
  logic [NUM_SRC-1:0]    hw_set, force_set, clr_set, state;
  logic                  unused_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  fifo_irq_cfg #(.CW(CW)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .en_o       (en),
    .prog_lvl_o (prog_lvl),
    .rd_lvl_o   (rd_lvl),
    .fclr_o     (fifo_clr_o)
  );

  fifo_irq_cond #(.DEPTH(DEPTH), .CW(CW)) u_cond (
    .prog_depth_i (prog_depth_i),
    .rd_depth_i   (rd_depth_i),
    .prog_lvl_i   (prog_lvl),
    .rd_lvl_i     (rd_lvl),
    .cond_o       (cond)
  );

  assign hw_set    = {corr_err_i, op_done_i, cond};
  assign force_set = (reg_wr_i && reg_addr_i == ADR_FORCE) ? reg_wdata_i[NUM_SRC-1:0] : '0;
  assign clr_set   = (reg_wr_i && reg_addr_i == ADR_STATE) ? reg_wdata_i[NUM_SRC-1:0] : '0;
  assign unused_wdata = ^reg_wdata_i;

  fifo_irq_state u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .hw_set_i (hw_set),
    .force_i  (force_set),
    .clr_i    (clr_set),
    .state_o  (state)
  );

  assign irq_o = state & en;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADR_STATE: reg_rdata_o[NUM_SRC-1:0] = state;
      ADR_EN:    reg_rdata_o[NUM_SRC-1:0] = en;
      ADR_WMARK: begin
        reg_rdata_o[CW-1:0]       = prog_lvl;
        reg_rdata_o[RD_LSB +: CW] = rd_lvl;
      end
      ADR_FCLR:  reg_rdata_o[0] = fifo_clr_o;
      ADR_DEPTH: begin
        reg_rdata_o[CW-1:0]       = prog_depth_i;
        reg_rdata_o[RD_LSB +: CW] = rd_depth_i;
      end
      default:   reg_rdata_o = '0;
    endcase
  end

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq_o & ~en) == '0); // R9
  AST_FORCE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_addr_i == ADR_FORCE) |-> (reg_rdata_o == '0)); // R8
  AST_RD_FULL_SETS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_depth_i == CW'(DEPTH)) |=> state[SRC_RD_FULL]); // R4
  AST_OP_DONE_SETS: assert property (@(posedge clk_i) disable iff (!rst_n)
    op_done_i |=> state[SRC_OP_DONE]); // R7
  AST_PROG_EMPTY_SETS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (prog_depth_i == '0) |=> state[SRC_PROG_EMPTY]); // R2
  AST_DEPTH_VIEW: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_addr_i == ADR_DEPTH) |-> (reg_rdata_o[CW-1:0] == prog_depth_i)); // R11
endmodule

// File: tb/fifo_irq_unit_tb.sv
module fifo_irq_unit_tb;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned CW    = $clog2(DEPTH + 1);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [CW-1:0] prog_depth, rd_depth;
  logic        op_done, corr_err;
  logic [5:0]  irq;
  logic        fifo_clr;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fifo_irq_unit #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .prog_depth_i(prog_depth), .rd_depth_i(rd_depth),
    .op_done_i(op_done), .corr_err_i(corr_err),
    .irq_o(irq), .fifo_clr_o(fifo_clr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic set_depth(input int p, input int r);
    @(negedge clk);
    prog_depth = CW'(p); rd_depth = CW'(r);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); check("R1 state", d, 32'h3);
    rd(3'd1, d); check("R1 enable", d, 32'h0);
    rd(3'd3, d); check("R1 wmark", d, 32'h0F0F);
    rd(3'd4, d); check("R1 fclr", d, 32'h0);
    check("R1 irq", {26'd0, irq}, 32'h0);
    check("R1 fifo_clr", {31'd0, fifo_clr}, 32'h0);
  endtask

  task automatic t_prog();
    logic [31:0] d;
    set_depth(5, 0);
    rd(3'd0, d); check("R2 prog not empty", d & 32'h1, 32'h0);
    check("R3 depth 5 below level 15", d & 32'h2, 32'h2);
    set_depth(15, 0);
    rd(3'd0, d); check("R3 depth equal level", d & 32'h2, 32'h2);
    set_depth(16, 0);
    rd(3'd0, d); check("R3 depth above level", d & 32'h2, 32'h0);
    wr(3'd3, 32'h0F04);
    set_depth(4, 0);
    rd(3'd0, d); check("R3 level 4 depth 4", d & 32'h2, 32'h2);
    set_depth(5, 0);
    rd(3'd0, d); check("R3 level 4 depth 5", d & 32'h2, 32'h0);
    set_depth(0, 0);
    rd(3'd0, d); check("R2 prog empty again", d & 32'h1, 32'h1);
  endtask

  task automatic t_rd();
    logic [31:0] d;
    wr(3'd3, 32'h0F0F);
    set_depth(0, 14);
    rd(3'd0, d); check("R5 rd 14 below level", d & 32'h8, 32'h0);
    set_depth(0, 15);
    rd(3'd0, d); check("R5 rd equal level", d & 32'h8, 32'h8);
    check("R4 rd 15 not full", d & 32'h4, 32'h0);
    set_depth(0, 16);
    rd(3'd0, d); check("R4 rd full", d & 32'hC, 32'hC);
    wr(3'd3, 32'h030F);
    set_depth(0, 2);
    rd(3'd0, d); check("R5 level 3 depth 2", d & 32'hC, 32'h0);
    set_depth(0, 3);
    rd(3'd0, d); check("R5 level 3 depth 3", d & 32'h8, 32'h8);
    wr(3'd3, 32'h0F0F);
  endtask

  task automatic t_status_w1c();
    logic [31:0] d;
    set_depth(0, 16);
    wr(3'd0, 32'h0F);
    rd(3'd0, d); check("R6 status ignores clear", d & 32'hF, 32'hF);
    set_depth(0, 0);
  endtask

  task automatic t_event();
    logic [31:0] d;
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
    repeat (3) @(negedge clk);
    rd(3'd0, d); check("R7 op_done latched", d & 32'h30, 32'h10);
    wr(3'd0, 32'h10);
    rd(3'd0, d); check("R7 op_done cleared", d & 32'h30, 32'h0);
    @(negedge clk); corr_err = 1'b1;
    @(negedge clk); corr_err = 1'b0;
    rd(3'd0, d); check("R7 corr_err latched", d & 32'h30, 32'h20);
    wr(3'd0, 32'h20);
    rd(3'd0, d); check("R7 corr_err cleared", d & 32'h30, 32'h0);
    @(negedge clk);
    op_done = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h10;
    @(negedge clk);
    op_done = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd(3'd0, d); check("R7 set beats clear", d & 32'h10, 32'h10);
    wr(3'd0, 32'h30);
  endtask

  task automatic t_force();
    logic [31:0] d;
    wr(3'd3, 32'h0F0F);
    set_depth(16, 0);
    wr(3'd2, 32'h3F);
    rd(3'd0, d); check("R8 force all bits", d, 32'h3F);
    @(negedge clk);
    rd(3'd0, d); check("R8 status force one cycle", d, 32'h30);
    rd(3'd2, d); check("R8 force reads zero", d, 32'h0);
    wr(3'd0, 32'h30);
    rd(3'd0, d); check("R8 forced events cleared", d, 32'h0);
    set_depth(0, 0);
  endtask

  task automatic t_irq();
    wr(3'd1, 32'h10);
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
    check("R9 op_done irq", {26'd0, irq}, 32'h10);
    wr(3'd1, 32'h0);
    check("R9 masked", {26'd0, irq}, 32'h0);
    wr(3'd1, 32'h01);
    check("R9 prog_empty irq", {26'd0, irq}, 32'h01);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h30);
  endtask

  task automatic t_fclr();
    logic [31:0] d;
    wr(3'd4, 32'h1);
    check("R10 fifo_clr high", {31'd0, fifo_clr}, 32'h1);
    rd(3'd4, d); check("R10 fclr readback", d, 32'h1);
    wr(3'd4, 32'h0);
    check("R10 fifo_clr low", {31'd0, fifo_clr}, 32'h0);
  endtask

  task automatic t_depth();
    logic [31:0] d;
    set_depth(7, 9);
    rd(3'd5, d); check("R11 depth view", d, 32'h0907);
    set_depth(16, 0);
    rd(3'd5, d); check("R11 depth view full prog", d, 32'h0010);
    set_depth(0, 0);
  endtask

  task automatic t_unused();
    logic [31:0] d;
    rd(3'd6, d); check("R12 addr 6", d, 32'h0);
    rd(3'd7, d); check("R12 addr 7", d, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); check("R12 enable width", d, 32'h3F);
    wr(3'd1, 32'h0);
    wr(3'd2, 32'hFFFF_FFC0);
    rd(3'd0, d); check("R12 state upper zero", d & 32'hFFFF_FFC0, 32'h0);
  endtask

  initial begin
    #50000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    prog_depth = '0; rd_depth = '0; op_done = 1'b0; corr_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_prog();
    t_rd();
    t_status_w1c();
    t_event();
    t_force();
    t_irq();
    t_fclr();
    t_depth();
    t_unused();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule